// File: doc/BRIEF.md
# Path Trace Identifier Monitor

This block watches the path trace byte of one channel. Upstream logic hands it one received trace byte per multiframe with a valid strobe. The block builds these bytes into messages. A message is either a single repeated byte or a 16-byte sequence, and the 16-byte form may be aligned on a start marker. Depending on a 3-bit mode, the block either captures the message into a set of detected-message registers or checks it against a programmed expected message.

In the checking modes, the block declares a trace mismatch after a programmable run of consecutive errored messages. It then drops back to hunting. It clears the mismatch only after two identical consecutive messages arrive, and it latches that agreed message as the new detected value. Because a message is accepted only when two in a row agree, a message hit by a stray bit error never reaches the detected registers.

The mismatch status drives an AIS request, which can be inhibited. Each change of status sets a sticky delta bit, which raises a maskable interrupt. A small register port gives access to the expected and detected messages and to the status.

Top module: `trace_id_monitor`

## Requirements
- R1: In mode 000 (unframed 16-byte capture), the bytes are numbered 0 to 15 in arrival order, counting from reset or from entry to the mode. Every 16th byte completes a message.
- R2: In modes 000, 001 and 010, and in the unused codes 101, 110 and 111, the mismatch status stays 0. In the unused codes, received bytes are ignored entirely.
- R3: In modes 001 and 011, a byte with bit 7 set is message byte 0, and the following bytes fill positions 1 to 15. Bytes with bit 7 clear that arrive before any marker are discarded. A marker arriving part-way through a message restarts the message at byte 0.
- R4: In mode 011, a completed message is errored if either of these holds: any byte differs from the expected message, or the CRC-7 of the received message differs from bits 6:0 of expected byte 0. The CRC uses polynomial x^7+x^3+1, starts from 0, runs MSB first over all 16 bytes, and treats bits 6:0 of byte 0 as zero. In mode 100, a byte is errored if it differs from expected byte 0.
- R5: While locked in mode 011 or 100, the mismatch status is set on the message that completes a run of consecutive errored messages equal to the 4-bit threshold. A good message resets the run. A threshold of 0 acts as 1.
- R6: In mode 011 or 100, the block hunts after reset, after entering the mode, and after declaring a mismatch. It returns to locked, and clears the mismatch status, only when two identical consecutive messages arrive after the hunt begins.
- R7: The detected registers load a message only when it equals the message before it. In the 1-byte modes only detected byte 0 loads. While locked, the detected registers never change.
- R8: `ais_req` is 1 exactly when the mismatch status is 1 and `ais_inhibit` is 0.
- R9: Every change of the mismatch status sets the sticky delta bit. `irq` is 1 exactly when delta is 1 and `irq_mask` is 0.
- R10: Writing a 1 to bit 1 of the status register (0x20) clears delta. A status change in the same cycle wins over the clear.
- R11: Register map: expected bytes 0 to 15 are at 0x00 to 0x0F (read/write). Detected bytes are at 0x10 to 0x1F (read only; writes are ignored). Status is at 0x20, with bit 0 = mismatch and bit 1 = delta. All other addresses read 0.
- R12: Reset clears the expected and detected messages, the message assembly, the run counter, the mismatch status and delta. The block starts hunting.
- R13: A mode change takes effect in the first cycle the new code is seen. In that cycle the byte input is ignored, assembly restarts, the previous message is forgotten and the block hunts. The mismatch status is kept only if the new mode is 011 or 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Received trace byte valid |
| byte_in | input | 8 | Received trace byte |
| mode | input | 3 | Capture/compare mode |
| mm_thresh | input | 4 | Consecutive errored messages needed for mismatch |
| ais_inhibit | input | 1 | Blocks the AIS request |
| irq_mask | input | 1 | Blocks the interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| trace_mismatch | output | 1 | Mismatch status |
| mismatch_delta | output | 1 | Sticky status-change bit |
| irq | output | 1 | Interrupt |
| ais_req | output | 1 | AIS request contribution |

## Verification
The status, the detected registers, delta, `irq` and `ais_req` all take their new values at the same rising edge that samples the byte completing a message. There is no extra pipeline register. A mode change acts at the first edge that sees the new code. Register reads are combinational, so a read is checked within the same cycle its address is driven.

The bench changes inputs just after a rising edge. A behavioural model advances at each rising edge, and every output is compared against the model at the following falling edge. Checks of the detected registers are made by reading them in the cycle after the completing byte.

// File: rtl/trace_mon_pkg.sv
package trace_mon_pkg;

    localparam int MSG_LEN = 16;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = $clog2(MSG_LEN);
    localparam int CRC_W   = 7;

    typedef logic [BYTE_W-1:0]               byte_t;
    typedef logic [MSG_LEN-1:0][BYTE_W-1:0]  msg_t;
    typedef logic [2:0]                      mode_t;

    localparam mode_t MD_GRAB16  = 3'b000;
    localparam mode_t MD_GRAB16F = 3'b001;
    localparam mode_t MD_GRAB1   = 3'b010;
    localparam mode_t MD_CHK16F  = 3'b011;
    localparam mode_t MD_CHK1    = 3'b100;

    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    typedef enum logic {SY_HUNT, SY_LOCK} sync_st_t;

    function automatic logic is_monitor(input mode_t m);
        return (m == MD_CHK16F) || (m == MD_CHK1);
    endfunction

    function automatic logic is_single(input mode_t m);
        return (m == MD_GRAB1) || (m == MD_CHK1);
    endfunction

    function automatic logic is_framed(input mode_t m);
        return (m == MD_GRAB16F) || (m == MD_CHK16F);
    endfunction

    function automatic logic is_active(input mode_t m);
        return m <= MD_CHK1;
    endfunction

    // Bit-serial CRC-7 over the whole message, MSB first, field bits of byte 0 zeroed.
    function automatic logic [CRC_W-1:0] crc7_msg(input msg_t m);
        logic [CRC_W-1:0] c;
        logic             fb;
        byte_t            b;
        c = '0;
        for (int i = 0; i < MSG_LEN; i++) begin
            b = (i == 0) ? {m[i][BYTE_W-1], {(BYTE_W-1){1'b0}}} : m[i];
            for (int k = BYTE_W-1; k >= 0; k--) begin
                fb = c[CRC_W-1] ^ b[k];
                c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/tm_assembler.sv
module tm_assembler
    import trace_mon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  byte_vld,
    input  byte_t byte_in,
    input  mode_t mode,
    output logic  restart,
    output logic  seq_done,
    output msg_t  seq_msg
);

    mode_t            mode_q;
    logic [IDX_W-1:0] pos_q, pos_d, wr_idx;
    msg_t             buf_q;
    logic             take;

    assign restart = (mode != mode_q);

    always_comb begin
        take     = 1'b0;
        seq_done = 1'b0;
        wr_idx   = pos_q;
        pos_d    = pos_q;
        if (byte_vld && !restart && is_active(mode)) begin
            if (is_single(mode)) begin
                take     = 1'b1;
                wr_idx   = '0;
                seq_done = 1'b1;
            end else if (is_framed(mode)) begin
                if (byte_in[BYTE_W-1]) begin
                    take   = 1'b1;
                    wr_idx = '0;
                    pos_d  = IDX_W'(1);
                end else if (pos_q != '0) begin
                    take     = 1'b1;
                    pos_d    = pos_q + 1'b1;
                    seq_done = (pos_q == IDX_W'(MSG_LEN-1));
                end
            end else begin
                take     = 1'b1;
                pos_d    = pos_q + 1'b1;
                seq_done = (pos_q == IDX_W'(MSG_LEN-1));
            end
        end
    end

    // Completed message with the arriving byte merged in, so results land this edge.
    always_comb begin
        seq_msg = buf_q;
        if (take) seq_msg[wr_idx] = byte_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_GRAB16;
            pos_q  <= '0;
            buf_q  <= '0;
        end else begin
            mode_q <= mode;
            pos_q  <= restart ? '0 : pos_d;
            if (take) buf_q <= seq_msg;
        end
    end

    AST_FRAME_MARKER: assert property (@(posedge clk) disable iff (rst)
        (seq_done && is_framed(mode)) |-> seq_msg[0][BYTE_W-1]); // R3

endmodule

// File: rtl/tm_sync.sv
module tm_sync
    import trace_mon_pkg::*;
#(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_t            mode,
    input  logic [THR_W-1:0] thresh,
    input  logic             restart,
    input  logic             seq_done,
    input  msg_t             seq_msg,
    input  msg_t             exp_msg,
    output logic             tim,
    output logic             tim_chg,
    output msg_t             det_msg
);

    sync_st_t         st_q, st_d;
    logic [THR_W-1:0] cnt_q, cnt_d;
    msg_t             prev_q, prev_d, det_q, det_d;
    logic             prev_vld_q, prev_vld_d;
    logic             tim_q, tim_d;
    logic             same, bad, latch;
    logic [THR_W:0]   thr_eff, run_next;

    always_comb begin
        if (is_single(mode)) begin
            same = prev_vld_q && (seq_msg[0] == prev_q[0]);
            bad  = (seq_msg[0] != exp_msg[0]);
        end else begin
            same = prev_vld_q && (seq_msg == prev_q);
            bad  = (seq_msg != exp_msg) || (crc7_msg(seq_msg) != exp_msg[0][CRC_W-1:0]);
        end
        thr_eff  = (thresh == '0) ? (THR_W+1)'(1) : {1'b0, thresh};
        run_next = {1'b0, cnt_q} + (THR_W+1)'(1);
    end

    always_comb begin
        st_d       = st_q;
        cnt_d      = cnt_q;
        prev_d     = prev_q;
        prev_vld_d = prev_vld_q;
        tim_d      = tim_q;
        latch      = 1'b0;
        if (restart) begin
            prev_vld_d = 1'b0;
            st_d       = SY_HUNT;
            cnt_d      = '0;
        end else if (seq_done) begin
            prev_d     = seq_msg;
            prev_vld_d = 1'b1;
            if (!is_monitor(mode)) begin
                latch = same;
            end else if (st_q == SY_HUNT) begin
                if (same) begin
                    latch = 1'b1;
                    st_d  = SY_LOCK;
                    cnt_d = '0;
                    tim_d = 1'b0;
                end
            end else if (bad) begin
                if (run_next >= thr_eff) begin
                    tim_d      = 1'b1;
                    st_d       = SY_HUNT;
                    cnt_d      = '0;
                    prev_vld_d = 1'b0;
                end else begin
                    cnt_d = run_next[THR_W-1:0];
                end
            end else begin
                cnt_d = '0;
            end
        end
        if (!is_monitor(mode)) tim_d = 1'b0;
    end

    always_comb begin
        det_d = det_q;
        if (latch) begin
            if (is_single(mode)) det_d[0] = seq_msg[0];
            else                 det_d    = seq_msg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= SY_HUNT;
            cnt_q      <= '0;
            prev_q     <= '0;
            prev_vld_q <= 1'b0;
            tim_q      <= 1'b0;
            det_q      <= '0;
        end else begin
            st_q       <= st_d;
            cnt_q      <= cnt_d;
            prev_q     <= prev_d;
            prev_vld_q <= prev_vld_d;
            tim_q      <= tim_d;
            det_q      <= det_d;
        end
    end

    assign tim     = tim_q;
    assign tim_chg = (tim_d != tim_q);
    assign det_msg = det_q;

    AST_TIM_RISE_AT_SEQ: assert property (@(posedge clk) disable iff (rst)
        $rose(tim_q) |-> $past(seq_done)); // R5
    AST_TIM_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(tim_q) |-> ($past(seq_done) || !is_monitor($past(mode)))); // R6
    AST_TIM_OFF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !is_monitor(mode) |=> !tim_q); // R2
    AST_DET_HELD_LOCK: assert property (@(posedge clk) disable iff (rst)
        (st_q == SY_LOCK && is_monitor(mode) && !restart) |=> $stable(det_q)); // R7

endmodule

// File: rtl/tm_regs.sv
module tm_regs
    import trace_mon_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  byte_t             reg_wdata,
    input  msg_t              det_msg,
    input  logic              tim,
    input  logic              tim_chg,
    input  logic              irq_mask,
    output msg_t              exp_msg,
    output byte_t             reg_rdata,
    output logic              delta,
    output logic              irq
);

    localparam int PAGE_W = ADDR_W - IDX_W;
    localparam logic [PAGE_W-1:0] PG_EXP  = PAGE_W'(0);
    localparam logic [PAGE_W-1:0] PG_DET  = PAGE_W'(1);
    localparam logic [PAGE_W-1:0] PG_STAT = PAGE_W'(2);

    logic [PAGE_W-1:0] page;
    logic [IDX_W-1:0]  idx;
    msg_t              exp_q;
    logic              delta_q;
    logic              clr_delta;

    assign page      = reg_addr[ADDR_W-1:IDX_W];
    assign idx       = reg_addr[IDX_W-1:0];
    assign clr_delta = reg_wr && (page == PG_STAT) && (idx == '0) && reg_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q   <= '0;
            delta_q <= 1'b0;
        end else begin
            if (reg_wr && page == PG_EXP) exp_q[idx] <= reg_wdata;
            if (tim_chg)        delta_q <= 1'b1;
            else if (clr_delta) delta_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (page == PG_EXP)                     reg_rdata = exp_q[idx];
        else if (page == PG_DET)                reg_rdata = det_msg[idx];
        else if (page == PG_STAT && idx == '0)  reg_rdata = {{(BYTE_W-2){1'b0}}, delta_q, tim};
    end

    assign exp_msg = exp_q;
    assign delta   = delta_q;
    assign irq     = delta_q & ~irq_mask;

    AST_DELTA_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (tim != $past(tim)) |-> delta_q); // R9
    AST_DELTA_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_delta && !tim_chg) |=> !delta_q); // R10

endmodule

// File: rtl/trace_id_monitor.sv
module trace_id_monitor
    import trace_mon_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int THR_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic [2:0]        mode,
    input  logic [THR_W-1:0]  mm_thresh,
    input  logic              ais_inhibit,
    input  logic              irq_mask,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              trace_mismatch,
    output logic              mismatch_delta,
    output logic              irq,
    output logic              ais_req
);

    logic restart, seq_done, tim, tim_chg;
    msg_t seq_msg, exp_msg, det_msg;

    tm_assembler u_asm (
        .clk      (clk),
        .rst      (rst),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .mode     (mode),
        .restart  (restart),
        .seq_done (seq_done),
        .seq_msg  (seq_msg)
    );

    tm_sync #(.THR_W(THR_W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .thresh   (mm_thresh),
        .restart  (restart),
        .seq_done (seq_done),
        .seq_msg  (seq_msg),
        .exp_msg  (exp_msg),
        .tim      (tim),
        .tim_chg  (tim_chg),
        .det_msg  (det_msg)
    );

    tm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .det_msg   (det_msg),
        .tim       (tim),
        .tim_chg   (tim_chg),
        .irq_mask  (irq_mask),
        .exp_msg   (exp_msg),
        .reg_rdata (reg_rdata),
        .delta     (mismatch_delta),
        .irq       (irq)
    );

    assign trace_mismatch = tim;
    assign ais_req        = tim & ~ais_inhibit;

    AST_AIS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ($rose(trace_mismatch) && !ais_inhibit) |-> ais_req); // R8

endmodule

// File: tb/trace_id_monitor_bench.sv
module trace_id_monitor_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = '0;
    logic [2:0] mode = 3'b000;
    logic [3:0] mm_thresh = 4'd3;
    logic       ais_inhibit = 1'b0;
    logic       irq_mask = 1'b0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       trace_mismatch, mismatch_delta, irq, ais_req;

    trace_id_monitor u_trace_id_monitor (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in), .mode(mode),
        .mm_thresh(mm_thresh), .ais_inhibit(ais_inhibit), .irq_mask(irq_mask),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trace_mismatch(trace_mismatch), .mismatch_delta(mismatch_delta), .irq(irq),
        .ais_req(ais_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [7:0] m [16]);
        int c = 0;
        for (int i = 0; i < 16; i++) begin
            for (int k = 7; k >= 0; k--) begin
                int bv = (i == 0 && k < 7) ? 0 : int'(m[i][k]);
                int fb = ((c >> 6) & 1) ^ bv;
                c = (c << 1) & 127;
                if (fb != 0) c = c ^ 9;
            end
        end
        return 7'(c);
    endfunction

    // Behavioural reference model.
    logic [7:0] m_buf[16], m_prev[16], m_det[16], m_exp[16];
    int   m_pos, m_cnt, m_n;
    bit   m_pvld, m_hunt, m_tim, m_delta, m_done, m_same, m_bad, m_old, m_mon;
    logic [2:0] m_mode_q;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) begin
                m_buf[i] = 0; m_prev[i] = 0; m_det[i] = 0; m_exp[i] = 0;
            end
            m_pos = 0; m_cnt = 0; m_pvld = 0; m_hunt = 1; m_tim = 0; m_delta = 0;
            m_mode_q = 3'b000;
        end else begin
            m_old  = m_tim;
            m_done = 0;
            m_mon  = (mode == 3'd3) || (mode == 3'd4);
            if (mode != m_mode_q) begin
                m_pos = 0; m_pvld = 0; m_hunt = 1; m_cnt = 0;
            end else if (byte_vld && mode <= 3'd4) begin
                if (mode == 3'd2 || mode == 3'd4) begin
                    m_buf[0] = byte_in; m_done = 1;
                end else if (mode == 3'd1 || mode == 3'd3) begin
                    if (byte_in[7]) begin
                        m_buf[0] = byte_in; m_pos = 1;
                    end else if (m_pos != 0) begin
                        m_buf[m_pos] = byte_in;
                        if (m_pos == 15) begin m_done = 1; m_pos = 0; end
                        else m_pos++;
                    end
                end else begin
                    m_buf[m_pos] = byte_in;
                    if (m_pos == 15) begin m_done = 1; m_pos = 0; end
                    else m_pos++;
                end
            end
            if (m_done) begin
                m_n = (mode == 3'd2 || mode == 3'd4) ? 1 : 16;
                m_same = m_pvld;
                m_bad = 0;
                for (int i = 0; i < m_n; i++) begin
                    if (m_buf[i] != m_prev[i]) m_same = 0;
                    if (m_buf[i] != m_exp[i]) m_bad = 1;
                end
                if (m_n == 16 && ref_crc(m_buf) != m_exp[0][6:0]) m_bad = 1;
                for (int i = 0; i < m_n; i++) m_prev[i] = m_buf[i];
                m_pvld = 1;
                if (!m_mon) begin
                    if (m_same) for (int i = 0; i < m_n; i++) m_det[i] = m_buf[i];
                end else if (m_hunt) begin
                    if (m_same) begin
                        for (int i = 0; i < m_n; i++) m_det[i] = m_buf[i];
                        m_hunt = 0; m_cnt = 0; m_tim = 0;
                    end
                end else if (m_bad) begin
                    m_cnt++;
                    if (m_cnt >= ((mm_thresh == 0) ? 1 : int'(mm_thresh))) begin
                        m_tim = 1; m_hunt = 1; m_cnt = 0; m_pvld = 0;
                    end
                end else m_cnt = 0;
            end
            if (!m_mon) m_tim = 0;
            if (reg_wr && reg_addr < 6'd16) m_exp[reg_addr[3:0]] = reg_wdata;
            if (m_tim != m_old) m_delta = 1;
            else if (reg_wr && reg_addr == 6'h20 && reg_wdata[1]) m_delta = 0;
            m_mode_q = mode;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R5 trace_mismatch vs model", {7'b0, trace_mismatch}, {7'b0, m_tim});
            check("R9 mismatch_delta vs model", {7'b0, mismatch_delta}, {7'b0, m_delta});
            check("R9 irq vs model", {7'b0, irq}, {7'b0, m_delta & ~irq_mask});
            check("R8 ais_req vs model", {7'b0, ais_req}, {7'b0, m_tim & ~ais_inhibit});
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 50000", cycles);
            summary();
        end
    end

    // Every task starts and ends one time unit after a rising edge.
    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask
    task automatic send_byte(input logic [7:0] b);
        byte_vld = 1'b1; byte_in = b;
        @(posedge clk); #1;
        byte_vld = 1'b0;
    endtask
    task automatic send_msg(input logic [7:0] m [16], input int n);
        for (int i = 0; i < n; i++) send_byte(m[i]);
    endtask
    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask
    task automatic rd_check(input logic [5:0] a, input logic [7:0] expv, input string tag);
        reg_addr = a;
        @(negedge clk);
        check(tag, reg_rdata, expv);
        @(posedge clk); #1;
    endtask
    task automatic port_check(input logic act_sel, input logic expv, input string tag);
        @(negedge clk);
        check(tag, {7'b0, act_sel ? trace_mismatch : mismatch_delta}, {7'b0, expv});
        @(posedge clk); #1;
    endtask
    task automatic set_mode(input logic [2:0] m);
        mode = m; idle(2);
    endtask

    logic [7:0] msgA[16], msgB[16], msgC[16], msgE[16], msgU[16];

    initial begin
        msgA[0] = 8'h80; msgB[0] = 8'h80;
        for (int i = 1; i < 16; i++) begin
            msgA[i] = 8'(8'h41 + i);
            msgB[i] = 8'(8'h61 + i);
        end
        msgA[0] = 8'h80 | {1'b0, ref_crc(msgA)};
        msgB[0] = 8'h80 | {1'b0, ref_crc(msgB)};
        for (int i = 0; i < 16; i++) begin
            msgC[i] = msgA[i]; msgE[i] = msgA[i]; msgU[i] = 8'(8'h10 + i);
        end
        msgC[0] = msgA[0] ^ 8'h01;
        msgE[7] = msgA[7] ^ 8'h01;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R12: reset state
        @(negedge clk);
        check("R12 mismatch after reset", {7'b0, trace_mismatch}, 8'h0);
        check("R12 delta after reset", {7'b0, mismatch_delta}, 8'h0);
        check("R12 irq after reset", {7'b0, irq}, 8'h0);
        @(posedge clk); #1;
        rd_check(6'h10, 8'h00, "R12 detected byte 0 after reset");
        rd_check(6'h05, 8'h00, "R12 expected byte 5 after reset");
        rd_check(6'h20, 8'h00, "R12 status after reset");

        // R1: unframed capture needs two equal messages
        send_msg(msgU, 16);
        rd_check(6'h13, 8'h00, "R7 single message not latched");
        send_msg(msgU, 16);
        rd_check(6'h13, msgU[3], "R1 detected byte 3");
        rd_check(6'h1F, msgU[15], "R1 detected byte 15");
        wr(6'h12, 8'hFF);
        rd_check(6'h12, msgU[2], "R11 detected is read only");
        rd_check(6'h21, 8'h00, "R11 unmapped reads zero");

        // R3: framed capture
        set_mode(3'd1);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
        send_msg(msgA, 16); send_msg(msgA, 16);
        rd_check(6'h10, msgA[0], "R3 marker in detected byte 0");
        rd_check(6'h15, msgA[5], "R3 detected byte 5 aligned");
        send_msg(msgB, 5);
        send_msg(msgB, 16); send_msg(msgB, 16);
        rd_check(6'h15, msgB[5], "R3 marker restarts message");

        // R7: single byte capture with a bit error
        set_mode(3'd2);
        send_byte(8'h3C); send_byte(8'h3C);
        rd_check(6'h10, 8'h3C, "R7 single byte latched");
        send_byte(8'h3D); send_byte(8'h3C);
        rd_check(6'h10, 8'h3C, "R7 bit error not latched");

        // R2: unused code ignores bytes
        set_mode(3'd5);
        send_byte(8'h11); send_byte(8'h11);
        rd_check(6'h10, 8'h3C, "R2 unused mode ignores bytes");

        // R5/R6/R8/R9/R10: single byte monitor
        wr(6'h00, 8'h55);
        mm_thresh = 4'd3;
        set_mode(3'd4);
        send_byte(8'h55); send_byte(8'h55);
        send_byte(8'h54); send_byte(8'h54); send_byte(8'h55);
        send_byte(8'h54); send_byte(8'h54);
        port_check(1'b1, 1'b0, "R5 run reset by good byte");
        send_byte(8'h54);
        port_check(1'b1, 1'b1, "R5 mismatch at threshold");
        rd_check(6'h20, 8'h03, "R11 status register");
        ais_inhibit = 1'b1;
        @(negedge clk);
        check("R8 ais inhibited", {7'b0, ais_req}, 8'h0);
        @(posedge clk); #1;
        send_byte(8'h54);
        port_check(1'b1, 1'b1, "R6 one message does not resync");
        send_byte(8'h54);
        port_check(1'b1, 1'b0, "R6 two equal messages resync");
        rd_check(6'h10, 8'h54, "R7 agreed byte latched");
        wr(6'h20, 8'h02);
        port_check(1'b0, 1'b0, "R10 delta cleared");
        irq_mask = 1'b1;
        mm_thresh = 4'd0;
        send_byte(8'h54);
        port_check(1'b1, 1'b1, "R5 threshold 0 acts as 1");
        @(negedge clk);
        check("R9 irq masked", {7'b0, irq}, 8'h0);
        @(posedge clk); #1;
        set_mode(3'd2);
        port_check(1'b1, 1'b0, "R13 capture mode clears mismatch");

        // R4: framed monitor with CRC
        irq_mask = 1'b0;
        wr(6'h20, 8'h02);
        for (int i = 0; i < 16; i++) wr(6'(i), msgA[i]);
        mm_thresh = 4'd2;
        set_mode(3'd3);
        send_msg(msgA, 16); send_msg(msgA, 16);
        send_msg(msgE, 16);
        port_check(1'b1, 1'b0, "R5 below threshold");
        send_msg(msgE, 16);
        port_check(1'b1, 1'b1, "R4 byte mismatch declared");
        rd_check(6'h17, msgA[7], "R7 locked detected unchanged");
        send_msg(msgA, 16); send_msg(msgA, 16);
        port_check(1'b1, 1'b0, "R6 framed resync");
        wr(6'h00, msgC[0]);
        set_mode(3'd1);
        set_mode(3'd3);
        send_msg(msgC, 16); send_msg(msgC, 16);
        port_check(1'b1, 1'b0, "R6 hunt locks on equal pair");
        send_msg(msgC, 16); send_msg(msgC, 16);
        port_check(1'b1, 1'b1, "R4 CRC error declared");
        set_mode(3'd4);
        port_check(1'b1, 1'b1, "R13 monitor mode keeps mismatch");
        set_mode(3'd0);
        port_check(1'b1, 1'b0, "R2 capture mode mismatch zero");

        idle(2);
        summary();
    end

endmodule